// File: doc/BRIEF.md
# Floating-Point Mantissa Rounding Unit

This block takes an unpacked floating-point mantissa that carries two extra low-order bits (guard and round) together with a separate sticky bit. It rounds the mantissa in one of four directed modes, taking the operand sign into account. It returns the rounded mantissa without the two extra bits, plus a rounded-up indication and the inexact, fraction-inexact and fraction-rounded status bits. When the increment carries out of the kept field, the value 2.0 is passed on unchanged; renormalising it is the consumer's job.

Alongside the rounding result, the block decides what an overflowing result should become in the selected mode: infinity, or the largest finite magnitude. It raises an overflow status bit whenever it chooses infinity. Every result is registered and appears one clock after the input strobe.

Top module: `fp_mant_round`

## Requirements
- R1: When `in_mant[1:0]` (guard at bit 1, round at bit 0) and `in_sticky` are all zero, `out_mant` equals `in_mant >> 2`, and `out_up`, `out_inexact`, `out_frac_inexact` and `out_frac_rounded` are all 0.
- R2: When any of guard, round or sticky is 1, both `out_inexact` and `out_frac_inexact` are 1.
- R3: In mode 2'b00 (nearest), the kept field is incremented only when guard is 1 and at least one of round, sticky or the kept least significant bit (`in_mant[2]`) is 1. A tie with an even kept value stays unchanged.
- R4: Mode 2'b01 (toward zero) never increments. Mode 2'b10 (toward plus infinity) increments an inexact value only when `in_sign` is 0. Mode 2'b11 (toward minus infinity) increments an inexact value only when `in_sign` is 1.
- R5: On an increment, `out_mant` equals the kept field plus 1 with full carry, and `out_up` and `out_frac_rounded` are 1. Without an increment, both of them are 0.
- R6: A carry out of an all-ones kept field yields `out_mant` = 1 << MANT_W (the value 2.0), which is not corrected.
- R7: `out_to_inf` is 1 in mode 2'b00 and 0 in mode 2'b01. In mode 2'b10 it equals the inverse of `in_sign`, and in mode 2'b11 it equals `in_sign`.
- R8: `out_ovf_flag` is 1 exactly when `out_to_inf` is 1.
- R9: Outputs load on a clock edge where `in_valid` is 1. `out_valid` is `in_valid` delayed by one clock.
- R10: An active-low reset clears `out_valid` and every status output (`out_up`, `out_inexact`, `out_frac_inexact`, `out_frac_rounded`, `out_to_inf`, `out_ovf_flag`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe |
| in_mant | input | MANT_W+2 | Kept mantissa field above guard (bit 1) and round (bit 0) |
| in_sticky | input | 1 | OR of all bits below the round bit |
| in_sign | input | 1 | Operand sign, 1 = negative |
| in_mode | input | 2 | Rounding mode: 00 nearest, 01 toward zero, 10 toward +inf, 11 toward -inf |
| out_valid | output | 1 | Result strobe |
| out_mant | output | MANT_W+1 | Rounded mantissa with the carry-out bit on top |
| out_up | output | 1 | An increment took place |
| out_inexact | output | 1 | Inexact status |
| out_frac_inexact | output | 1 | Fraction-inexact status |
| out_frac_rounded | output | 1 | Fraction-rounded status |
| out_to_inf | output | 1 | Overflow resolves to infinity (0: largest finite magnitude) |
| out_ovf_flag | output | 1 | Overflow status |

## Verification
The assertions assume that `in_mant`, `in_sticky`, `in_sign` and `in_mode` carry defined values whenever `in_valid` is high. They also assume that each result is sampled in the cycle right after its strobe. Every 2-bit mode value is legal, so the properties allow any mode. The stimulus always drives fully defined inputs and spans all four modes, both signs and every guard, round and sticky combination. It also inserts idle cycles between strobes, so the one-cycle relation is checked with and without back-to-back traffic.

// File: rtl/fp_rnd_pkg.sv
package fp_rnd_pkg;

   typedef enum logic [1:0] {
      RM_NEAREST = 2'b00,
      RM_ZERO    = 2'b01,
      RM_POS     = 2'b10,
      RM_NEG     = 2'b11
   } rnd_mode_e;

endpackage

// File: rtl/fp_rnd_decide.sv
module fp_rnd_decide
   import fp_rnd_pkg::*;
(
   input  rnd_mode_e mode,
   input  logic      sign,
   input  logic      lsb,
   input  logic      guard_b,
   input  logic      round_b,
   input  logic      sticky_b,
   output logic      inexact,
   output logic      inc
);

   always_comb begin
      inexact = guard_b | round_b | sticky_b;
      inc     = 1'b0;
      unique case (mode)
         RM_NEAREST: inc = guard_b & (round_b | sticky_b | lsb);
         RM_ZERO:    inc = 1'b0;
         RM_POS:     inc = inexact & ~sign;
         RM_NEG:     inc = inexact & sign;
      endcase
   end

endmodule

// File: rtl/fp_ovf_select.sv
module fp_ovf_select
   import fp_rnd_pkg::*;
(
   input  rnd_mode_e mode,
   input  logic      sign,
   output logic      to_inf
);

   always_comb begin
      to_inf = 1'b0;
      unique case (mode)
         RM_NEAREST: to_inf = 1'b1;
         RM_ZERO:    to_inf = 1'b0;
         RM_POS:     to_inf = ~sign;
         RM_NEG:     to_inf = sign;
      endcase
   end

endmodule

// File: rtl/fp_rnd_incr.sv
module fp_rnd_incr #(
   parameter int W          = 24,
   parameter int SEG_W      = 8,
   parameter int FAST_CARRY = 1
) (
   input  logic [W-1:0] a,
   input  logic         inc,
   output logic [W:0]   sum
);

   localparam int NSEG = (W + SEG_W - 1) / SEG_W;

   initial begin
      assert (W >= 2) else $error("fp_rnd_incr: W must be at least 2");
      assert (SEG_W >= 1) else $error("fp_rnd_incr: SEG_W must be positive");
      assert (FAST_CARRY == 0 || (W % SEG_W) == 0)
         else $error("fp_rnd_incr: W must be a multiple of SEG_W");
   end

   generate
      if (FAST_CARRY != 0) begin : g_seg
         logic [NSEG:0] cy;
         assign cy[0] = inc;
         for (genvar k = 0; k < NSEG; k++) begin : g_blk
            logic [SEG_W-1:0] blk;
            assign blk       = a[k*SEG_W +: SEG_W];
            assign cy[k+1]   = cy[k] & (&blk);
            assign sum[k*SEG_W +: SEG_W] = blk + SEG_W'(cy[k]);
         end
         assign sum[W] = cy[NSEG];
      end else begin : g_ripple
         assign sum = {1'b0, a} + (W+1)'(inc);
      end
   endgenerate

endmodule

// File: rtl/fp_mant_round.sv
module fp_mant_round
   import fp_rnd_pkg::*;
#(
   parameter int MANT_W     = 24,
   parameter int SEG_W      = 8,
   parameter int FAST_CARRY = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [MANT_W+1:0] in_mant,
   input  logic              in_sticky,
   input  logic              in_sign,
   input  logic [1:0]        in_mode,
   output logic              out_valid,
   output logic [MANT_W:0]   out_mant,
   output logic              out_up,
   output logic              out_inexact,
   output logic              out_frac_inexact,
   output logic              out_frac_rounded,
   output logic              out_to_inf,
   output logic              out_ovf_flag
);

   localparam int IN_W  = MANT_W + 2;
   localparam int OUT_W = MANT_W + 1;

   initial begin
      assert (MANT_W >= 2) else $error("fp_mant_round: MANT_W too small");
   end

   logic [MANT_W-1:0] kept;
   logic              guard_b;
   logic              round_b;
   rnd_mode_e         mode;
   logic              inexact_c;
   logic              inc_c;
   logic              to_inf_c;
   logic [OUT_W-1:0]  sum_c;

   assign kept    = in_mant[IN_W-1:2];
   assign guard_b = in_mant[1];
   assign round_b = in_mant[0];
   assign mode    = rnd_mode_e'(in_mode);

   fp_rnd_decide u_decide (
      .mode     (mode),
      .sign     (in_sign),
      .lsb      (kept[0]),
      .guard_b  (guard_b),
      .round_b  (round_b),
      .sticky_b (in_sticky),
      .inexact  (inexact_c),
      .inc      (inc_c)
   );

   fp_rnd_incr #(
      .W          (MANT_W),
      .SEG_W      (SEG_W),
      .FAST_CARRY (FAST_CARRY)
   ) u_incr (
      .a   (kept),
      .inc (inc_c),
      .sum (sum_c)
   );

   fp_ovf_select u_ovf (
      .mode   (mode),
      .sign   (in_sign),
      .to_inf (to_inf_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid        <= 1'b0;
         out_mant         <= '0;
         out_up           <= 1'b0;
         out_inexact      <= 1'b0;
         out_frac_inexact <= 1'b0;
         out_frac_rounded <= 1'b0;
         out_to_inf       <= 1'b0;
         out_ovf_flag     <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_mant         <= sum_c;
            out_up           <= inc_c;
            out_inexact      <= inexact_c;
            out_frac_inexact <= inexact_c;
            out_frac_rounded <= inc_c;
            out_to_inf       <= to_inf_c;
            out_ovf_flag     <= to_inf_c;
         end
      end
   end

endmodule

// File: rtl/fp_mant_round_chk.sv
module fp_mant_round_chk #(
   parameter int MANT_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [MANT_W+1:0] in_mant,
   input logic              in_sticky,
   input logic              in_sign,
   input logic [1:0]        in_mode,
   input logic              out_valid,
   input logic [MANT_W:0]   out_mant,
   input logic              out_up,
   input logic              out_inexact,
   input logic              out_frac_inexact,
   input logic              out_frac_rounded,
   input logic              out_to_inf,
   input logic              out_ovf_flag
);

   AST_EXACT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_mant[1:0] == 2'b00 && !in_sticky |=>
         !out_up && !out_inexact && out_mant == {1'b0, $past(in_mant[MANT_W+1:2])}); // R1

   AST_INEXACT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (in_mant[1:0] != 2'b00 || in_sticky) |=> out_inexact && out_frac_inexact); // R2

   AST_NEAREST_NO_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_mode == 2'b00 && !in_mant[1] |=> !out_up); // R3

   AST_ZERO_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_mode == 2'b01 |=> !out_up); // R4

   AST_POS_MODE_NEG: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_mode == 2'b10 && in_sign |=> !out_up); // R4

   AST_UP_TRACKS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_up == out_frac_rounded); // R5

   AST_NEAREST_TO_INF: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_mode == 2'b00 |=> out_to_inf); // R7

   AST_ZERO_NOT_INF: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_mode == 2'b01 |=> !out_to_inf); // R7

   AST_INF_RAISES_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      out_to_inf |-> out_ovf_flag); // R8

   AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R9

   AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R9

endmodule

bind fp_mant_round fp_mant_round_chk #(.MANT_W(MANT_W)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .in_valid         (in_valid),
   .in_mant          (in_mant),
   .in_sticky        (in_sticky),
   .in_sign          (in_sign),
   .in_mode          (in_mode),
   .out_valid        (out_valid),
   .out_mant         (out_mant),
   .out_up           (out_up),
   .out_inexact      (out_inexact),
   .out_frac_inexact (out_frac_inexact),
   .out_frac_rounded (out_frac_rounded),
   .out_to_inf       (out_to_inf),
   .out_ovf_flag     (out_ovf_flag)
);

// File: tb/fp_mant_round_test.sv
module fp_mant_round_test;

   localparam int MW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [MW+1:0] in_mant = '0;
   logic          in_sticky = 1'b0;
   logic          in_sign = 1'b0;
   logic [1:0]    in_mode = 2'b00;
   logic          out_valid;
   logic [MW:0]   out_mant;
   logic          out_up, out_inexact, out_frac_inexact, out_frac_rounded;
   logic          out_to_inf, out_ovf_flag;

   always #10 clk = ~clk;

   fp_mant_round #(.MANT_W(MW)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mant(in_mant),
      .in_sticky(in_sticky), .in_sign(in_sign), .in_mode(in_mode),
      .out_valid(out_valid), .out_mant(out_mant), .out_up(out_up),
      .out_inexact(out_inexact), .out_frac_inexact(out_frac_inexact),
      .out_frac_rounded(out_frac_rounded), .out_to_inf(out_to_inf),
      .out_ovf_flag(out_ovf_flag)
   );

   typedef struct {
      longint mant;
      bit     up;
      bit     inx;
      bit     inf;
      string  tag;
   } exp_t;

   exp_t q[$];
   bit   vq[$];
   int   checks = 0;
   int   fails  = 0;
   bit   done   = 0;

   task automatic chk(string tag, longint act, longint expv);
      checks++;
      if (act != expv) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   function automatic exp_t model(longint m, bit s, bit sg, int mode, string tag);
      exp_t   e;
      longint kept = m >> 2;
      bit     g = m[1];
      bit     r = m[0];
      bit     inc;
      e.inx = g | r | s;
      case (mode)
         0: inc = g & (r | s | kept[0]);
         1: inc = 0;
         2: inc = e.inx & !sg;
         default: inc = e.inx & sg;
      endcase
      case (mode)
         0: e.inf = 1;
         1: e.inf = 0;
         2: e.inf = !sg;
         default: e.inf = sg;
      endcase
      e.up   = inc;
      e.mant = kept + (inc ? 1 : 0);
      e.tag  = tag;
      return e;
   endfunction

   task automatic compare_pending();
      if (vq.size() > 0) begin
         bit ev = vq.pop_front();
         chk("R9 out_valid", out_valid, ev);
         if (ev) begin
            exp_t e = q.pop_front();
            chk({e.tag, " out_mant"}, out_mant, e.mant);
            chk({e.tag, " R5 out_up"}, out_up, e.up);
            chk("R5 out_frac_rounded", out_frac_rounded, e.up);
            chk("R2 out_inexact", out_inexact, e.inx);
            chk("R2 out_frac_inexact", out_frac_inexact, e.inx);
            chk("R7 out_to_inf", out_to_inf, e.inf);
            chk("R8 out_ovf_flag", out_ovf_flag, e.inf);
         end
      end
   endtask

   task automatic step(string tag, bit v, longint m, bit s, bit sg, int mode);
      @(negedge clk);
      compare_pending();
      in_valid  = v;
      in_mant   = m[MW+1:0];
      in_sticky = s;
      in_sign   = sg;
      in_mode   = mode[1:0];
      vq.push_back(v);
      if (v) q.push_back(model(m, s, sg, mode, tag));
   endtask

   task automatic check_reset_state(string tag);
      chk({tag, " R10 out_valid"}, out_valid, 0);
      chk({tag, " R10 out_up"}, out_up, 0);
      chk({tag, " R10 out_inexact"}, out_inexact, 0);
      chk({tag, " R10 out_frac_inexact"}, out_frac_inexact, 0);
      chk({tag, " R10 out_frac_rounded"}, out_frac_rounded, 0);
      chk({tag, " R10 out_to_inf"}, out_to_inf, 0);
      chk({tag, " R10 out_ovf_flag"}, out_ovf_flag, 0);
   endtask

   task automatic report();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      check_reset_state("initial");
      rst_n = 1'b1;

      // R1: exact inputs pass through in every mode
      step("R1", 1, (longint'('hABCDEF) << 2), 0, 0, 0);
      step("R1", 1, (longint'('hABCDEF) << 2), 0, 0, 2);
      step("R1", 1, (longint'('h800001) << 2), 0, 1, 3);
      // R3: nearest, ties to even, guard-only, round-only
      step("R3", 1, (longint'('hABCDEE) << 2) | 2, 0, 0, 0);
      step("R3", 1, (longint'('hABCDEF) << 2) | 2, 0, 0, 0);
      step("R3", 1, (longint'('hABCDEE) << 2) | 2, 1, 1, 0);
      step("R3", 1, (longint'('hABCDEE) << 2) | 1, 1, 0, 0);
      // R4: directed modes against sign
      step("R4", 1, (longint'('h123456) << 2) | 3, 1, 0, 1);
      step("R4", 1, (longint'('h123456) << 2) | 1, 0, 0, 2);
      step("R4", 1, (longint'('h123456) << 2) | 1, 0, 1, 2);
      step("R4", 1, (longint'('h123456) << 2), 1, 1, 3);
      step("R4", 1, (longint'('h123456) << 2), 1, 0, 3);
      // R6: carry out of an all-ones field gives 2.0
      step("R6", 1, (longint'('hFFFFFF) << 2) | 3, 0, 0, 0);
      step("R6", 1, (longint'('hFFFFFF) << 2), 1, 1, 3);
      step("R6", 0, 0, 0, 0, 0);

      // random traffic with idle gaps
      for (int i = 0; i < 400; i++) begin
         longint m = longint'($urandom) & ((longint'(1) << (MW + 2)) - 1);
         if ((i % 17) == 0) m = m | 'h3FFFFFC;
         step("R5", ($urandom % 4) != 0, m, $urandom % 2, $urandom % 2,
              int'($urandom % 4));
      end
      step("R9", 0, 0, 0, 0, 0);
      step("R9", 0, 0, 0, 0, 0);

      // R10: reset in the middle of traffic clears the status outputs
      step("R10", 1, (longint'('h00000F) << 2) | 3, 1, 0, 0);
      @(negedge clk);
      compare_pending();
      in_valid = 1'b0;
      rst_n = 1'b0;
      #1;
      check_reset_state("mid-run");
      vq.delete();
      q.delete();
      @(negedge clk);
      rst_n = 1'b1;
      step("R1", 1, (longint'('h555555) << 2), 0, 1, 1);
      step("R9", 0, 0, 0, 0, 0);
      step("R9", 0, 0, 0, 0, 0);
      report();
   end

endmodule